// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a virtual address into a physical address using two levels of lookup. The virtual address carries, from most to least significant, a segment number, a page number within that segment, and a byte offset within the page. The segment number selects an entry in a small register-based segment table. Each entry holds a valid bit, the base address of that segment's page table, the segment length in bytes, and three permission flags: readable, writable and shareable.

Once a request is accepted, the block checks the entry before any memory traffic is generated. An invalid entry gives a segment fault. A page-and-offset span at or past the segment length gives a limit fault. An access that the flags forbid gives a protection fault. Only when all three checks pass does the block issue one read of the external page-table memory, at the segment's base plus the page number. It then joins the returned frame number with the unchanged offset to form the physical address. Software fills the segment table through a dedicated write port. Only one translation is in flight at a time.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address is `{segment, page, offset}`. With the defaults, the segment is bits [13:12], the page is bits [11:8] and the offset is bits [7:0].
- R2: A request whose segment entry has its valid bit clear completes with `res_fault` = 1 (segment fault). This check has the highest priority.
- R3: If the entry is valid and the 12-bit span `{page, offset}` is greater than or equal to the 13-bit segment length, the request completes with `res_fault` = 2 (limit fault). In that case `pt_rd_en` is never asserted for the request.
- R4: If the entry is valid and within the limit, a write to a segment whose writable flag is clear, or a read from a segment whose readable flag is clear, completes with `res_fault` = 3 (protection fault). No page-table read is issued for it.
- R5: A request that passes all checks causes exactly one `pt_rd_en` pulse. Its `pt_rd_addr` is the segment base plus the zero-extended page number, modulo 2^PTB_W. The page-table memory returns `pt_rd_data` one cycle after it samples `pt_rd_en`.
- R6: A successful request completes with `res_fault` = 0 and `res_paddr` = `{frame, offset}`, where the frame is the page-table word that was read.
- R7: `req_ready` is high only when the block is idle. It falls in the cycle after a request is accepted and rises again in the cycle in which `res_valid` pulses for one cycle. Request inputs seen while `req_ready` is low are ignored.
- R8: A write through the segment-table port replaces the whole entry at `st_idx` and takes effect for requests checked after it. Reset clears every valid bit. On success, `res_shared` reports the entry's shareable flag; it is 0 on any fault.
- R9: After reset, `req_ready` is 1 and both `res_valid` and `pt_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | SEG_W+PAGE_W+OFF_W | Virtual address {segment, page, offset} |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| st_we | input | 1 | Segment table entry write strobe |
| st_idx | input | SEG_W | Entry to write |
| st_valid | input | 1 | New valid bit |
| st_base | input | PTB_W | New page-table base address |
| st_len | input | PAGE_W+OFF_W+1 | New segment length in bytes |
| st_rd | input | 1 | New readable flag |
| st_wr | input | 1 | New writable flag |
| st_share | input | 1 | New shareable flag |
| pt_rd_en | output | 1 | Page-table memory read strobe |
| pt_rd_addr | output | PTB_W | Page-table memory word address |
| pt_rd_data | input | FRAME_W | Frame number, one cycle after the strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 2 | 0 ok, 1 segment, 2 limit, 3 protection |
| res_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset} |
| res_shared | output | 1 | Shareable flag of a successful translation |

## Verification
The bench targets the exact length boundary, where a span equal to the length must fault while a span one less must pass. An off-by-one comparator would let the last byte through or block it. It stacks several violations on one request to confirm the fault order; a design with the wrong order would report a protection fault for an invalid or over-long segment. It places a page-table base near the top of the address range so that base plus page wraps, and it counts page-table strobes on faulting requests, which a design that reads memory before checking would not keep at zero. It also holds changing request inputs during a busy translation, and it rewrites entries between requests, which catches a design that latches late inputs or keeps stale table contents.

// File: rtl/spx_pkg.sv
package spx_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SEG   = 2'd1,
        FLT_LIMIT = 2'd2,
        FLT_PROT  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DATA  = 2'd3
    } state_e;

endpackage

// File: rtl/spx_seg_table.sv
module spx_seg_table #(
    parameter int SEG_W  = 2,
    parameter int PTB_W  = 12,
    parameter int LENF_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  widx,
    input  logic              wvalid,
    input  logic [PTB_W-1:0]  wbase,
    input  logic [LENF_W-1:0] wlen,
    input  logic              wrd,
    input  logic              wwr,
    input  logic              wshare,
    input  logic [SEG_W-1:0]  ridx,
    output logic              rvalid,
    output logic [PTB_W-1:0]  rbase,
    output logic [LENF_W-1:0] rlen,
    output logic              rrd,
    output logic              rwr,
    output logic              rshare
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic              vld;
        logic [PTB_W-1:0]  base;
        logic [LENF_W-1:0] len;
        logic              rd;
        logic              wr;
        logic              sh;
    } entry_t;

    entry_t ent_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        entry_t ent_d;

        always_comb begin
            ent_d = ent_q[i];
            if (we && (widx == SEG_W'(i))) begin
                ent_d.vld  = wvalid;
                ent_d.base = wbase;
                ent_d.len  = wlen;
                ent_d.rd   = wrd;
                ent_d.wr   = wwr;
                ent_d.sh   = wshare;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d;
            end
        end
    end

    always_comb begin
        rvalid = ent_q[ridx].vld;
        rbase  = ent_q[ridx].base;
        rlen   = ent_q[ridx].len;
        rrd    = ent_q[ridx].rd;
        rwr    = ent_q[ridx].wr;
        rshare = ent_q[ridx].sh;
    end

endmodule

// File: rtl/spx_access_check.sv
module spx_access_check
    import spx_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 8,
    parameter int PTB_W  = 12
) (
    input  logic                    ent_valid,
    input  logic [PTB_W-1:0]        ent_base,
    input  logic [PAGE_W+OFF_W:0]   ent_len,
    input  logic                    ent_rd,
    input  logic                    ent_wr,
    input  logic [PAGE_W-1:0]       page,
    input  logic [OFF_W-1:0]        off,
    input  logic                    is_write,
    output fault_e                  fault,
    output logic [PTB_W-1:0]        pt_addr
);
    localparam int SPAN_W = PAGE_W + OFF_W;

    logic [SPAN_W:0] span;
    logic            perm_ok;

    always_comb begin
        span    = {1'b0, page, off};
        perm_ok = is_write ? ent_wr : ent_rd;
        if (!ent_valid) begin
            fault = FLT_SEG;
        end else if (span >= ent_len) begin
            fault = FLT_LIMIT;
        end else if (!perm_ok) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
        pt_addr = ent_base + {{(PTB_W-PAGE_W){1'b0}}, page};
    end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
    import spx_pkg::*;
#(
    parameter int SEG_W   = 2,
    parameter int PAGE_W  = 4,
    parameter int OFF_W   = 8,
    parameter int PTB_W   = 12,
    parameter int FRAME_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
    input  logic                          req_write,
    input  logic                          st_we,
    input  logic [SEG_W-1:0]              st_idx,
    input  logic                          st_valid,
    input  logic [PTB_W-1:0]              st_base,
    input  logic [PAGE_W+OFF_W:0]         st_len,
    input  logic                          st_rd,
    input  logic                          st_wr,
    input  logic                          st_share,
    output logic                          pt_rd_en,
    output logic [PTB_W-1:0]              pt_rd_addr,
    input  logic [FRAME_W-1:0]            pt_rd_data,
    output logic                          res_valid,
    output logic [1:0]                    res_fault,
    output logic [FRAME_W+OFF_W-1:0]      res_paddr,
    output logic                          res_shared
);
    localparam int VA_W   = SEG_W + PAGE_W + OFF_W;
    localparam int PA_W   = FRAME_W + OFF_W;
    localparam int LENF_W = PAGE_W + OFF_W + 1;

    typedef struct packed {
        state_e            st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              share_pend;
        logic              pt_en;
        logic [PTB_W-1:0]  pt_addr;
        logic              rv;
        fault_e            flt;
        logic [PA_W-1:0]   pa;
        logic              sh;
    } regs_t;

    regs_t r_d, r_q;

    logic [SEG_W-1:0]  cur_seg;
    logic [PAGE_W-1:0] cur_page;
    logic [OFF_W-1:0]  cur_off;

    assign cur_seg  = r_q.va[VA_W-1 -: SEG_W];
    assign cur_page = r_q.va[OFF_W +: PAGE_W];
    assign cur_off  = r_q.va[OFF_W-1:0];

    logic              e_valid, e_rd, e_wr, e_share;
    logic [PTB_W-1:0]  e_base;
    logic [LENF_W-1:0] e_len;
    fault_e            chk_fault;
    logic [PTB_W-1:0]  chk_pt_addr;

    spx_seg_table #(
        .SEG_W (SEG_W),
        .PTB_W (PTB_W),
        .LENF_W(LENF_W)
    ) i_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .widx  (st_idx),
        .wvalid(st_valid),
        .wbase (st_base),
        .wlen  (st_len),
        .wrd   (st_rd),
        .wwr   (st_wr),
        .wshare(st_share),
        .ridx  (cur_seg),
        .rvalid(e_valid),
        .rbase (e_base),
        .rlen  (e_len),
        .rrd   (e_rd),
        .rwr   (e_wr),
        .rshare(e_share)
    );

    spx_access_check #(
        .PAGE_W(PAGE_W),
        .OFF_W (OFF_W),
        .PTB_W (PTB_W)
    ) i_check (
        .ent_valid(e_valid),
        .ent_base (e_base),
        .ent_len  (e_len),
        .ent_rd   (e_rd),
        .ent_wr   (e_wr),
        .page     (cur_page),
        .off      (cur_off),
        .is_write (r_q.wr),
        .fault    (chk_fault),
        .pt_addr  (chk_pt_addr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rv    = 1'b0;
        r_d.pt_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va = req_vaddr;
                    r_d.wr = req_write;
                    r_d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (chk_fault != FLT_NONE) begin
                    r_d.rv  = 1'b1;
                    r_d.flt = chk_fault;
                    r_d.pa  = '0;
                    r_d.sh  = 1'b0;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.pt_en      = 1'b1;
                    r_d.pt_addr    = chk_pt_addr;
                    r_d.share_pend = e_share;
                    r_d.st         = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_DATA;
            end
            ST_DATA: begin
                r_d.rv  = 1'b1;
                r_d.flt = FLT_NONE;
                r_d.pa  = {pt_rd_data, cur_off};
                r_d.sh  = r_q.share_pend;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign pt_rd_en   = r_q.pt_en;
    assign pt_rd_addr = r_q.pt_addr;
    assign res_valid  = r_q.rv;
    assign res_fault  = r_q.flt;
    assign res_paddr  = r_q.pa;
    assign res_shared = r_q.sh;

endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
    parameter int OFF_W   = 8,
    parameter int FRAME_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [OFF_W-1:0]         req_off,
    input logic                     pt_rd_en,
    input logic [FRAME_W-1:0]       pt_rd_data,
    input logic                     res_valid,
    input logic [1:0]               res_fault,
    input logic [FRAME_W+OFF_W-1:0] res_paddr
);
    localparam int PA_W = FRAME_W + OFF_W;

    logic [OFF_W-1:0] off_q;
    logic             pt_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q     <= '0;
            pt_seen_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_q     <= req_off;
            pt_seen_q <= 1'b0;
        end else if (pt_rd_en) begin
            pt_seen_q <= 1'b1;
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7
    AST_PT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> !req_ready); // R7
    AST_FAULT_NO_PT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> !pt_seen_q); // R3
    AST_PT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> !pt_rd_en); // R5
    AST_OK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0) |-> pt_seen_q); // R5
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0) |-> res_paddr[OFF_W-1:0] == off_q); // R6
    AST_FRAME_FROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0) |-> res_paddr[PA_W-1:OFF_W] == $past(pt_rd_data)); // R6

endmodule

bind seg_page_xlate spx_checker #(
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .pt_rd_en  (pt_rd_en),
    .pt_rd_data(pt_rd_data),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_paddr (res_paddr)
);

// File: tb/test_seg_page_xlate.sv
module test_seg_page_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 2, PAGE_W = 4, OFF_W = 8, PTB_W = 12, FRAME_W = 8;
    localparam int VA_W = SEG_W + PAGE_W + OFF_W;
    localparam int PA_W = FRAME_W + OFF_W;
    localparam int LENF_W = PAGE_W + OFF_W + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, req_write;
    logic [VA_W-1:0] req_vaddr;
    logic st_we, st_valid, st_rd, st_wr, st_share;
    logic [SEG_W-1:0] st_idx;
    logic [PTB_W-1:0] st_base;
    logic [LENF_W-1:0] st_len;
    logic pt_rd_en;
    logic [PTB_W-1:0] pt_rd_addr;
    logic [FRAME_W-1:0] pt_rd_data;
    logic res_valid, res_shared;
    logic [1:0] res_fault;
    logic [PA_W-1:0] res_paddr;

    int n_chk = 0;
    int n_bad = 0;

    logic              m_vld [4];
    logic [PTB_W-1:0]  m_base[4];
    logic [LENF_W-1:0] m_len [4];
    logic              m_rd [4], m_wr [4], m_sh [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_page_xlate i_seg_page_xlate (.*);

    function automatic logic [FRAME_W-1:0] frame_of(input logic [PTB_W-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (pt_rd_en) pt_rd_data <= frame_of(pt_rd_addr);

    function automatic logic [1:0] exp_fault(input logic [VA_W-1:0] va, input logic wr);
        int s;
        s = int'(va[VA_W-1 -: SEG_W]);
        if (!m_vld[s]) return 2'd1;
        if ({1'b0, va[PAGE_W+OFF_W-1:0]} >= m_len[s]) return 2'd2;
        if (wr ? !m_wr[s] : !m_rd[s]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [PTB_W-1:0] exp_pt(input logic [VA_W-1:0] va);
        int s;
        s = int'(va[VA_W-1 -: SEG_W]);
        return m_base[s] + PTB_W'(va[OFF_W +: PAGE_W]);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_seg(input int s, input logic v, input logic [PTB_W-1:0] b,
                          input logic [LENF_W-1:0] l, input logic r, input logic w, input logic sh);
        @(negedge clk);
        st_we = 1'b1; st_idx = SEG_W'(s); st_valid = v; st_base = b;
        st_len = l; st_rd = r; st_wr = w; st_share = sh;
        m_vld[s] = v; m_base[s] = b; m_len[s] = l; m_rd[s] = r; m_wr[s] = w; m_sh[s] = sh;
        @(negedge clk);
        st_we = 1'b0;
    endtask

    task automatic xlate(input logic [VA_W-1:0] va, input logic wr, input bit hold);
        logic [1:0] ef;
        logic [PTB_W-1:0] ept, got_pt;
        int npt, guard;
        bit busy_bad;
        ef  = exp_fault(va, wr);
        ept = exp_pt(va);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (hold) begin
            req_vaddr = ~va; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        npt = 0; guard = 0; busy_bad = 0; got_pt = '0;
        while (!res_valid && guard < 50) begin
            if (pt_rd_en) begin npt++; got_pt = pt_rd_addr; end
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        chk(res_valid, "R7 result pulse arrives", longint'(res_valid), 1);
        chk(!busy_bad, "R7 ready low while busy", longint'(busy_bad), 0);
        chk(res_fault == ef, "R2/R3/R4 fault code", longint'(res_fault), longint'(ef));
        if (ef == 2'd0) begin
            chk(npt == 1, "R5 one page-table read", npt, 1);
            chk(got_pt == ept, "R5 page-table address", longint'(got_pt), longint'(ept));
            chk(res_paddr == {frame_of(ept), va[OFF_W-1:0]}, "R6 R1 physical address",
                longint'(res_paddr), longint'({frame_of(ept), va[OFF_W-1:0]}));
            chk(res_shared == m_sh[int'(va[VA_W-1 -: SEG_W])], "R8 shared flag",
                longint'(res_shared), longint'(m_sh[int'(va[VA_W-1 -: SEG_W])]));
        end else begin
            chk(npt == 0, "R3 no page-table read on fault", npt, 0);
            chk(res_shared == 1'b0, "R8 shared low on fault", longint'(res_shared), 0);
        end
        @(negedge clk);
        chk(!res_valid, "R7 result is one cycle", longint'(res_valid), 0);
    endtask

    function automatic logic [VA_W-1:0] va_of(input int s, input int p, input int o);
        return {SEG_W'(s), PAGE_W'(p), OFF_W'(o)};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        st_we = 1'b0; st_idx = '0; st_valid = 1'b0; st_base = '0; st_len = '0;
        st_rd = 1'b0; st_wr = 1'b0; st_share = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_vld[i] = 0; m_base[i] = '0; m_len[i] = '0; m_rd[i] = 0; m_wr[i] = 0; m_sh[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", longint'(req_ready), 1);
        chk(res_valid == 1'b0, "R9 no result after reset", longint'(res_valid), 0);
        chk(pt_rd_en == 1'b0, "R9 no read after reset", longint'(pt_rd_en), 0);

        // R8: reset leaves all entries invalid -> segment fault
        xlate(va_of(2, 1, 5), 1'b0, 0);

        // R6 R1: plain successful read and write
        wr_seg(0, 1, 12'h100, 13'h1000, 1, 1, 0);
        xlate(va_of(0, 3, 8'h25), 1'b0, 0);
        xlate(va_of(0, 15, 8'hFF), 1'b1, 0);

        // R3 boundary: span equal to length faults, one less passes
        wr_seg(1, 1, 12'h200, 13'h0325, 1, 1, 1);
        xlate(va_of(1, 3, 8'h25), 1'b0, 0);
        xlate(va_of(1, 3, 8'h24), 1'b0, 0);
        wr_seg(1, 1, 12'h200, 13'h0000, 1, 1, 1);
        xlate(va_of(1, 0, 0), 1'b0, 0);

        // R4: read-only segment written, write-only segment read
        wr_seg(2, 1, 12'h300, 13'h0800, 1, 0, 1);
        xlate(va_of(2, 2, 9), 1'b1, 0);
        xlate(va_of(2, 2, 9), 1'b0, 0);
        wr_seg(3, 1, 12'h400, 13'h0800, 0, 1, 0);
        xlate(va_of(3, 1, 1), 1'b0, 0);
        xlate(va_of(3, 1, 1), 1'b1, 0);

        // R2/R3/R4 priority: invalid beats limit, limit beats protection
        wr_seg(3, 0, 12'h400, 13'h0010, 0, 0, 0);
        xlate(va_of(3, 9, 0), 1'b1, 0);
        wr_seg(3, 1, 12'h400, 13'h0010, 0, 0, 0);
        xlate(va_of(3, 9, 0), 1'b1, 0);

        // R5: base plus page wraps
        wr_seg(0, 1, 12'hFFE, 13'h1000, 1, 1, 1);
        xlate(va_of(0, 5, 8'h77), 1'b0, 0);

        // R7: inputs changed while busy are ignored
        xlate(va_of(0, 6, 8'h10), 1'b0, 1);

        // R8: rewritten entry becomes invalid
        wr_seg(0, 0, 12'hFFE, 13'h1000, 1, 1, 1);
        xlate(va_of(0, 6, 8'h10), 1'b0, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                wr_seg(int'($urandom_range(0, 3)), ($urandom_range(0, 4) != 0),
                       PTB_W'($urandom), LENF_W'($urandom_range(0, 4096)),
                       1'($urandom), 1'($urandom), 1'($urandom));
            end
            xlate(VA_W'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule